// File: doc/BRIEF.md
# Match Channel Bank

This block holds eight additional timer channels, numbered 4 through 11. Each channel owns a counter, a match value and a control word. The control word picks which of five externally generated rate ticks advances the counter. It also sets whether the channel compares against its own counter or against a counter shared inside its group, whether its counter returns to zero on a match, and whether the channel keeps firing or fires only once. When a channel's compared counter steps onto its match value, a per-channel status flag is raised. A single interrupt line stays high while any flag is set. Software clears the flags by writing ones.

Channels are grouped for counter sharing. Channels 4 to 7 can borrow the counter of channel 4, channels 8 and 9 can borrow channel 8's, and channels 10 and 11 can borrow channel 10's. Channels 9 and 11 can also be linked to their group head, so that a read of their counter latches the head's counter into a snapshot register in the same cycle. All state is reached through a simple word-aligned register bus with registered read data.

Top module: `match_chan_bank`

## Requirements
- R1: After reset every counter, match value, control word, status flag and the snapshot read as zero, `irq` is low, and no counter advances for any tick pattern.
- R2: Control bits [2:0] choose the rate: code k in 1..5 advances the counter by one on each cycle where `rate_tick[k-1]` is high (bit 0 32.768 kHz, bit 1 1 kHz, bit 2 1 Hz, bit 3 1 MHz, bit 4 external). Codes 0, 6 and 7 stop the counter.
- R3: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, channels 4–7 compare against channel 4's counter, 8–9 against channel 8's and 10–11 against channel 10's. A channel that is not a group head and has bit 7 clear does not advance its own counter.
- R4: When an armed channel's compared counter advances onto the channel's match value, status flag 4+k is set at that same clock edge (k = channel − 4). The flags read at offset 0x14, bits 11:4.
- R5: With control bit 3 set, a match loads the channel's own counter with zero in place of the match value.
- R6: With control bit 6 set, the channel stays armed after a match. With bit 6 clear, it disarms after its first match and re-arms only on a write to its match or control register.
- R7: Channels 4–7 store control bits [7:0] and read zero above them; channels 8–11 store bits [9:0]. On channels 8–11, control bit 8 set stops the counter whatever the rate code.
- R8: A read of the counter of channel 9 (or 11) while its control bit 9 is set copies the counter of channel 8 (or 10), as it stands in that cycle, into the snapshot register at offset 0x20.
- R9: Writing the status register clears each flag whose data bit is one and leaves the others. A match in the same cycle as the clearing write leaves that flag set.
- R10: `irq` is high exactly when at least one status flag is set, and changes at the same edge as the flags.
- R11: Counters sit at 0x40+4k, match values at 0x80+4k and control words at 0xC0+4k. A write to a counter loads it. Read data appears on `bus_rdata` one clock after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_tick | input | 5 | Single-cycle tick enables, one per selectable rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined match interrupt |

## Verification
The assertions assume that each rate tick is a one-cycle pulse, that bus addresses are word aligned, and that no write loads a counter in the same cycle in which that counter's selected tick arrives. The stimulus drives every input on the falling clock edge and issues one tick or one bus access per two-cycle slot. The only exception is a deliberate collision of a status-clearing write with a matching tick, which exercises the set-over-clear rule. Coverage extends to shared and own counters, halted wide channels, a one-shot channel being re-armed, and a linked snapshot read compared with an unlinked one.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int NCH      = 8;   // channels in the bank
  localparam int NRATE    = 5;   // selectable tick sources
  localparam int FIRST_CH = 4;   // number of the first channel
  localparam int NARROW   = 4;   // leading channels with the short control word
  localparam int AW       = 8;
  localparam int SW       = $clog2(NCH);
  localparam int CTRL_W   = 10;
  localparam logic [CTRL_W-1:0] CTRL_NARROW_KEEP = 10'h0FF;

  localparam logic [AW-1:0] A_STATUS = 8'h14;
  localparam logic [AW-1:0] A_SNAP   = 8'h20;
  localparam logic [2:0] REG_CNT   = 3'b010;  // 0x40..0x5C
  localparam logic [2:0] REG_MATCH = 3'b100;  // 0x80..0x9C
  localparam logic [2:0] REG_CTRL  = 3'b110;  // 0xC0..0xDC

  typedef struct packed {
    logic       snap_link;    // bit 9
    logic       halt;         // bit 8
    logic       own_cnt;      // bit 7
    logic       periodic;     // bit 6
    logic [1:0] spare;        // bits 5:4
    logic       clr_on_match; // bit 3
    logic [2:0] rate;         // bits 2:0
  } ctrl_t;

  // group head for a channel index (0-based within the bank)
  function automatic int leader_of(input int n);
    if (n < NARROW) return 0;
    return n - (n % 2);
  endfunction

  function automatic logic rate_hit(input logic [2:0] code,
                                    input logic [NRATE-1:0] t);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NRATE; k++)
      if (code == 3'(k + 1)) hit = t[k];
    return hit;
  endfunction
endpackage

// File: rtl/mcb_channel.sv
module mcb_channel
  import mcb_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit IS_LEADER = 1'b0,
  parameter bit WIDE      = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             match_we,
  input  logic             cnt_we,
  input  logic [DW-1:0]    wdata,
  input  logic [NRATE-1:0] ticks,
  input  logic [DW-1:0]    grp_cnt,
  input  logic             grp_step,
  output ctrl_t            ctrl_q,
  output logic [DW-1:0]    match_q,
  output logic [DW-1:0]    cnt_q,
  output logic             step,
  output logic             evt
);
  localparam logic [CTRL_W-1:0] KEEP = WIDE ? {CTRL_W{1'b1}} : CTRL_NARROW_KEEP;

  logic          armed_q;
  logic          use_own;
  logic          run;
  logic [DW-1:0] src_cnt;
  logic          src_step;
  logic [DW-1:0] src_next;

  assign use_own  = IS_LEADER || ctrl_q.own_cnt;
  assign run      = use_own && !ctrl_q.halt;
  assign step     = run && rate_hit(ctrl_q.rate, ticks);
  assign src_cnt  = use_own ? cnt_q : grp_cnt;
  assign src_step = use_own ? step : grp_step;
  assign src_next = src_cnt + 1'b1;
  assign evt      = armed_q && src_step && (src_next == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      match_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0] & KEEP);
      if (match_we) match_q <= wdata;
      if (ctrl_we || match_we)      armed_q <= 1'b1;
      else if (evt && !ctrl_q.periodic) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            cnt_q <= '0;
    else if (cnt_we)                    cnt_q <= wdata;
    else if (evt && ctrl_q.clr_on_match) cnt_q <= '0;
    else if (step)                      cnt_q <= cnt_q + 1'b1;
  end

  // R2: a counter without a tick, a load or a clear keeps its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && !step && !evt) |=> (cnt_q == $past(cnt_q)));

  // R5: a clearing match leaves the own counter at zero
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (evt && ctrl_q.clr_on_match && !cnt_we) |=> (cnt_q == '0));

  // R6: a one-shot channel is disarmed after it fires
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && !ctrl_q.periodic && !ctrl_we && !match_we) |=> !armed_q);
endmodule

// File: rtl/mcb_status.sv
module mcb_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] st_q,
  output logic         irq_q
);
  logic [N-1:0] st_next;

  assign st_next = (st_q & ~(clr_we ? clr_mask : '0)) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_next;
      irq_q <= |st_next;
    end
  end

  // R4 / R9: a match always lands in its flag, even against a clearing write
  assert_set_R4: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((st_q & $past(set)) == $past(set)));

  // R9: clearing write without a concurrent match empties the masked flags
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !(|set)) |=> ((st_q & $past(clr_mask)) == '0));

  // R10: interrupt tracks the flags
  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|st_q));
endmodule

// File: rtl/match_chan_bank.sv
module match_chan_bank
  import mcb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NRATE-1:0] rate_tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  logic [DW-1:0] cnt_q   [NCH];
  logic [DW-1:0] match_q [NCH];
  ctrl_t         ctrl_q  [NCH];
  logic [NCH-1:0] step_v;
  logic [NCH-1:0] evt_v;
  logic [NCH-1:0] st_q;

  logic          aligned;
  logic [SW-1:0] sel;
  logic [2:0]    region;
  logic          hit_cnt, hit_match, hit_ctrl, hit_stat, hit_snap;
  logic [SW-1:0] partner;
  logic [DW-1:0] partner_cnt;
  logic          snap_take;
  logic [DW-1:0] snap_q;
  logic [DW-1:0] rd_mux;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign sel       = bus_addr[2 +: SW];
  assign region    = bus_addr[AW-1 -: 3];
  assign hit_cnt   = aligned && (region == REG_CNT);
  assign hit_match = aligned && (region == REG_MATCH);
  assign hit_ctrl  = aligned && (region == REG_CTRL);
  assign hit_stat  = (bus_addr == A_STATUS);
  assign hit_snap  = (bus_addr == A_SNAP);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int LDR = leader_of(g);
    mcb_channel #(
      .DW       (DW),
      .IS_LEADER(LDR == g),
      .WIDE     (g >= NARROW)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .ctrl_we (bus_wr && hit_ctrl  && (sel == SW'(g))),
      .match_we(bus_wr && hit_match && (sel == SW'(g))),
      .cnt_we  (bus_wr && hit_cnt   && (sel == SW'(g))),
      .wdata   (bus_wdata),
      .ticks   (rate_tick),
      .grp_cnt (cnt_q[LDR]),
      .grp_step(step_v[LDR]),
      .ctrl_q  (ctrl_q[g]),
      .match_q (match_q[g]),
      .cnt_q   (cnt_q[g]),
      .step    (step_v[g]),
      .evt     (evt_v[g])
    );
  end

  mcb_status #(.N(NCH)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set     (evt_v),
    .clr_we  (bus_wr && hit_stat),
    .clr_mask(bus_wdata[FIRST_CH +: NCH]),
    .st_q    (st_q),
    .irq_q   (irq)
  );

  // linked read: odd wide channel latches its group head
  assign partner     = {sel[SW-1:1], 1'b0};
  assign partner_cnt = cnt_q[partner];
  assign snap_take   = bus_rd && hit_cnt && (sel >= SW'(NARROW)) && sel[0]
                       && ctrl_q[sel].snap_link;

  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (snap_take) snap_q <= partner_cnt;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cnt)        rd_mux = cnt_q[sel];
    else if (hit_match) rd_mux = match_q[sel];
    else if (hit_ctrl)  rd_mux = DW'(ctrl_q[sel]);
    else if (hit_stat)  rd_mux = DW'({st_q, {FIRST_CH{1'b0}}});
    else if (hit_snap)  rd_mux = snap_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: snapshot holds the partner counter seen in the reading cycle
  assert_snap_R8: assert property (@(posedge clk) disable iff (rst)
    snap_take |=> (snap_q == $past(partner_cnt)));

  // R11: read data only moves after a read strobe
  assert_rdhold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/match_chan_bank_test.sv
module match_chan_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rate_tick = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  match_chan_bank uut (
    .clk(clk), .rst(rst), .rate_tick(rate_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  localparam int NVEC = 20;
  // {op, addr, data, expected, requirement}
  localparam logic [77:0] VEC [NVEC] = '{
    {OP_WR, 8'hC0, 32'h84,  32'h0,  4'd2},  // R2 ch4 own, rate 1 MHz
    {OP_TK, 8'h00, 32'h08,  32'h0,  4'd2},  // R2 selected tick
    {OP_TK, 8'h00, 32'h01,  32'h0,  4'd2},  // R2 other tick ignored
    {OP_RD, 8'h40, 32'h0,   32'h1,  4'd2},  // R2 one step only
    {OP_WR, 8'h80, 32'h3,   32'h0,  4'd4},  // R4 match 3
    {OP_TK, 8'h00, 32'h08,  32'h0,  4'd4},
    {OP_RD, 8'h14, 32'h0,   32'h0,  4'd4},  // R4 no flag yet
    {OP_TK, 8'h00, 32'h08,  32'h0,  4'd4},  // counter reaches 3
    {OP_RD, 8'h14, 32'h0,   32'h10, 4'd4},  // R4 flag 4
    {OP_RD, 8'h40, 32'h0,   32'h3,  4'd11}, // R11 counter address
    {OP_WR, 8'h14, 32'h10,  32'h0,  4'd9},
    {OP_RD, 8'h14, 32'h0,   32'h0,  4'd9},  // R9 cleared
    {OP_WR, 8'hC4, 32'h02,  32'h0,  4'd3},  // R3 ch5 shares ch4
    {OP_WR, 8'h84, 32'h5,   32'h0,  4'd3},
    {OP_TK, 8'h00, 32'h08,  32'h0,  4'd3},
    {OP_TK, 8'h00, 32'h08,  32'h0,  4'd3},  // shared counter reaches 5
    {OP_RD, 8'h14, 32'h0,   32'h20, 4'd3},  // R3 flag 5 from ch4 counter
    {OP_TK, 8'h00, 32'h02,  32'h0,  4'd3},
    {OP_RD, 8'h44, 32'h0,   32'h0,  4'd3},  // R3 own counter idle
    {OP_RD, 8'hC4, 32'h0,   32'h02, 4'd11}  // R11 control readback
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input logic [4:0] m);
    @(negedge clk);
    rate_tick = m;
    @(negedge clk);
    rate_tick = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  logic [1:0]  v_op;
  logic [7:0]  v_addr;
  logic [31:0] v_data, v_exp, v_got;
  logic [3:0]  v_req;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 status", 8'h14, 32'h0);
    tick(5'h1F);
    rd_chk("R1 stopped", 8'h40, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      {v_op, v_addr, v_data, v_exp, v_req} = VEC[i];
      case (v_op)
        OP_WR: wr(v_addr, v_data);
        OP_TK: tick(v_data[4:0]);
        default: begin
          rd(v_addr, v_got);
          check($sformatf("R%0d vec %0d", v_req, i), v_got, v_exp);
        end
      endcase
    end

    // R10 / R9: zero bits leave flags, ones clear them
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h10);
    rd_chk("R9 keep", 8'h14, 32'h20);
    wr(8'h14, 32'hFFFF_FFFF);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    // R5 / R6: ch8 periodic, clear on match, match 2
    wr(8'hD0, 32'hC9);
    wr(8'h90, 32'h2);
    tick(5'h01); tick(5'h01);
    rd_chk("R5 cleared", 8'h50, 32'h0);
    rd_chk("R4 flag8", 8'h14, 32'h100);
    wr(8'h14, 32'h100);
    tick(5'h01); tick(5'h01);
    rd_chk("R6 periodic", 8'h14, 32'h100);
    wr(8'h14, 32'hFFF0);

    // R6: one-shot ch4 stays quiet until re-armed
    wr(8'h40, 32'h0);
    tick(5'h08); tick(5'h08); tick(5'h08);
    rd_chk("R6 disarmed", 8'h14, 32'h0);
    rd_chk("R11 load", 8'h40, 32'h3);
    wr(8'h80, 32'h5);
    tick(5'h08); tick(5'h08);
    rd_chk("R6 rearmed", 8'h14, 32'h10);

    // R9: match in the clearing cycle wins
    wr(8'h80, 32'h7);
    tick(5'h08);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h10; rate_tick = 5'h08;
    @(negedge clk);
    bus_wr = 1'b0; rate_tick = '0;
    rd_chk("R9 set wins", 8'h14, 32'h10);

    // R7: control widths and halt
    wr(8'hC8, 32'h3FF);
    rd_chk("R7 narrow", 8'hC8, 32'hFF);
    wr(8'hDC, 32'h3FF);
    rd_chk("R7 wide", 8'hDC, 32'h3FF);
    wr(8'hD8, 32'h181);
    tick(5'h01);
    rd_chk("R7 halted", 8'h58, 32'h0);
    wr(8'hD8, 32'h081);
    tick(5'h01);
    rd_chk("R2 ch10 runs", 8'h58, 32'h1);

    // R8: linked snapshot versus unlinked read
    wr(8'h50, 32'h1234);
    wr(8'hD4, 32'h280);
    rd_chk("R8 ch9 count", 8'h54, 32'h0);
    rd_chk("R8 snapshot", 8'h20, 32'h1234);
    wr(8'hD4, 32'h080);
    wr(8'h50, 32'h55);
    rd_chk("R8 ch9 count unlinked", 8'h54, 32'h0);
    rd_chk("R8 snapshot kept", 8'h20, 32'h1234);

    // R1: reset again
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_chk("R1 ctrl", 8'hC0, 32'h0);
    rd_chk("R1 match", 8'h80, 32'h0);
    rd_chk("R1 status", 8'h14, 32'h0);
    rd_chk("R1 snapshot", 8'h20, 32'h0);
    tick(5'h1F);
    rd_chk("R1 counter", 8'h50, 32'h0);

    summary();
  end
endmodule